// File: doc/BRIEF.md
# Two-Level Interrupt Concentrator

This block gathers 32 external interrupt request lines, called second-level sources, into 12 first-level interrupt outputs. Each request line first passes through a two-flop synchronizer. Its level is then normalized against a fixed inactive level for that bit, so that a set bit always means "requesting". Each source can be masked one by one. The sources that remain are folded into first-level lines through a fixed grouping table. Each first-level line has its own mask.

A byte-wide register port gives software three things:
- the synchronized raw levels of the four status bytes;
- the four second-level mask bytes;
- the two first-level mask bytes.

A demultiplex port accepts a first-level line number through a valid/ready request. It returns a vector through a valid/ready response:
- the number of the lowest-numbered pending, unmasked source in that line's group, or
- the line number itself when nothing in the group is pending.

The response register holds one entry. A new request is taken only when that slot is empty or is being emptied in the same cycle, so back-pressure on the response stalls the request side. While a response waits, it holds still until it is accepted.

Top module: `irq_tree_ctl`

## Requirements
- R1: After reset, every mask byte reads 0xFF, the status bytes read 0x00, all first-level outputs are 0, and no demultiplex response is valid.
- R2: Addresses 0..3 read the synchronized raw levels of status bytes 0..3, where source n is bit n%8 of byte n/8. Writes to these addresses have no effect.
- R3: A source is active when its synchronized level differs from its inactive level. The inactive pattern is 0x00 for byte 0, 0xBE for byte 1, 0xFC for byte 2 and 0xF7 for byte 3.
- R4: Addresses 4..7 hold the second-level mask bytes for status bytes 0..3. A 1 masks the source; a 0 enables it.
- R5: Address 8 holds the masks of lines 0..7 in bits 0..7. Address 9 holds the masks of lines 8..11 in bits 0..3. Bits 4..7 of address 9 always read 1 and ignore writes. A 1 masks the line. Addresses 10..15 read 0x00 and ignore writes.
- R6: First-level line n is asserted when it is unmasked and at least one active, unmasked source lies in its group. Each group is a (status byte, bitmask) pair:

  | Byte | Line: bitmask |
  | --- | --- |
  | 0 | 7: 0xFF |
  | 1 | 4: 0x01, 6: 0x3E, 8: 0x40, 9: 0x80 |
  | 2 | 0: 0x40, 1: 0x80, 5: 0x3C, 11: 0x03 |
  | 3 | 2: 0x08, 3: 0x01, 10: 0x06 |

  Sources 28..31 raise no line.
- R7: A change on a request input reaches the first-level outputs on the third rising edge. A mask write takes effect on the outputs at the edge after the write edge.
- R8: A demultiplex request for line L below 12 with a nonzero candidate byte returns byte*8 + (index of the lowest set bit). The candidate byte is active AND group bitmask AND NOT second-level mask.
- R9: A demultiplex request for line L below 12 with an empty candidate byte returns L, with the error flag clear. The first-level mask does not affect demultiplexing.
- R10: A demultiplex request for line 12..15 returns the line number, with the error flag set on that response.
- R11: `dmx_req_ready` equals (not `dmx_rsp_valid`) or `dmx_rsp_ready`. A request is accepted when valid and ready are both high. Its response is valid from the next cycle and holds still until `dmx_rsp_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw | input | 32 | Raw asynchronous request levels, source n on bit n |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| l1_irq | output | 12 | Registered first-level interrupt outputs |
| dmx_req_valid | input | 1 | Demultiplex request valid |
| dmx_req_ready | output | 1 | Demultiplex request ready |
| dmx_req_line | input | 4 | First-level line number to resolve |
| dmx_rsp_valid | output | 1 | Demultiplex response valid |
| dmx_rsp_ready | input | 1 | Demultiplex response ready |
| dmx_rsp_vec | output | 5 | Resolved source number or echoed line number |
| dmx_rsp_err | output | 1 | Line number out of range for this response |

## Verification
The assertions check a set of properties on every cycle:
- a masked first-level line never asserts;
- the upper nibble of the second first-level mask byte always reads as ones;
- an error response always carries an out-of-range line;
- a stalled response keeps its vector and flag.

Some behaviour only the bench's scenarios can show:
- the irregular group table;
- the per-byte inactive patterns;
- the lowest-bit priority;
- the three-edge input latency.

For these, a behavioural reference tracks walking single-source requests, random levels, random mask writes and randomly stalled demultiplex traffic, and is compared on every clock.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;

  localparam int BYTE_W    = 8;
  localparam int STAT_REGS = 4;
  localparam int SRC_N     = STAT_REGS * BYTE_W;
  localparam int LINES     = 12;
  localparam int L1_REGS   = (LINES + BYTE_W - 1) / BYTE_W;
  localparam int L1_BITS   = L1_REGS * BYTE_W;
  localparam int SEL_W     = $clog2(STAT_REGS);
  localparam int BIT_W     = $clog2(BYTE_W);
  localparam int VEC_W     = SEL_W + BIT_W;
  localparam int LINE_W    = 4;
  localparam int ADDR_W    = 4;
  localparam int L2M_BASE  = STAT_REGS;
  localparam int L1M_BASE  = 2 * STAT_REGS;

  // One first-level group: which status byte it looks at, and which bits.
  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [BYTE_W-1:0] bits;
  } group_t;

  // Grouping table; the order of entries is the line number.
  function automatic group_t group_of(input logic [LINE_W-1:0] line);
    group_t g;
    g = '0;
    case (line)
      4'd0:  g = {2'd2, 8'h40};
      4'd1:  g = {2'd2, 8'h80};
      4'd2:  g = {2'd3, 8'h08};
      4'd3:  g = {2'd3, 8'h01};
      4'd4:  g = {2'd1, 8'h01};
      4'd5:  g = {2'd2, 8'h3C};
      4'd6:  g = {2'd1, 8'h3E};
      4'd7:  g = {2'd0, 8'hFF};
      4'd8:  g = {2'd1, 8'h40};
      4'd9:  g = {2'd1, 8'h80};
      4'd10: g = {2'd3, 8'h06};
      4'd11: g = {2'd2, 8'h03};
      default: g = '0;
    endcase
    return g;
  endfunction

  // Level each status bit rests at when it is not requesting.
  function automatic logic [BYTE_W-1:0] idle_level(input int unsigned r);
    logic [BYTE_W-1:0] v;
    case (r)
      0:       v = 8'h00;
      1:       v = 8'hBE;
      2:       v = 8'hFC;
      3:       v = 8'hF7;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_tree_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic [SRC_N-1:0]    sync_raw,
  output logic [BYTE_W-1:0]   rdata,
  output logic [SRC_N-1:0]    l2_mask,
  output logic [LINES-1:0]    l1_mask
);

  localparam logic [L1_BITS-1:0] L1_IMPL = L1_BITS'((64'd1 << LINES) - 64'd1);

  logic [SRC_N-1:0]   l2_flat;
  logic [L1_BITS-1:0] l1_flat;

  // Mask storage; status bytes have no storage here, so writes to them vanish.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l2_flat <= '1;
      l1_flat <= '1;
    end else if (wr_en) begin
      for (int r = 0; r < STAT_REGS; r++) begin
        if (addr == ADDR_W'(L2M_BASE + r))
          l2_flat[r*BYTE_W +: BYTE_W] <= wdata;
      end
      for (int r = 0; r < L1_REGS; r++) begin
        if (addr == ADDR_W'(L1M_BASE + r))
          l1_flat[r*BYTE_W +: BYTE_W] <= wdata | ~L1_IMPL[r*BYTE_W +: BYTE_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < STAT_REGS; r++) begin
      if (addr == ADDR_W'(r))
        rdata = sync_raw[r*BYTE_W +: BYTE_W];
      if (addr == ADDR_W'(L2M_BASE + r))
        rdata = l2_flat[r*BYTE_W +: BYTE_W];
    end
    for (int r = 0; r < L1_REGS; r++) begin
      if (addr == ADDR_W'(L1M_BASE + r))
        rdata = l1_flat[r*BYTE_W +: BYTE_W];
    end
  end

  assign l2_mask = l2_flat;
  assign l1_mask = l1_flat[LINES-1:0];

endmodule

// File: rtl/irq_level_eval.sv
module irq_level_eval
  import irq_tree_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  sync_raw,
  input  logic [SRC_N-1:0]  l2_mask,
  input  logic [LINES-1:0]  l1_mask,
  output logic [SRC_N-1:0]  live_src,
  output logic [LINES-1:0]  l1_irq
);

  logic [SRC_N-1:0] active;
  logic [LINES-1:0] hit;

  // Polarity normalization per status byte.
  for (genvar r = 0; r < STAT_REGS; r++) begin : g_norm
    assign active[r*BYTE_W +: BYTE_W] = sync_raw[r*BYTE_W +: BYTE_W] ^ idle_level(r);
  end

  assign live_src = active & ~l2_mask;

  // Fold each group into its first-level line.
  for (genvar n = 0; n < LINES; n++) begin : g_line
    localparam group_t G   = group_of(LINE_W'(n));
    localparam int     SEL = int'(G.sel);
    assign hit[n] = |(live_src[SEL*BYTE_W +: BYTE_W] & G.bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) l1_irq <= '0;
    else        l1_irq <= hit & ~l1_mask;
  end

endmodule

// File: rtl/irq_demux.sv
module irq_demux
  import irq_tree_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  live_src,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LINE_W-1:0] req_line,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [VEC_W-1:0]  rsp_vec,
  output logic              rsp_err
);

  logic [VEC_W-1:0] pick_vec;
  logic             pick_err;

  always_comb begin
    group_t            g;
    logic [BYTE_W-1:0] lane;
    logic [BYTE_W-1:0] cand;
    logic [BIT_W-1:0]  low;
    g    = group_of(req_line);
    lane = '0;
    for (int r = 0; r < STAT_REGS; r++) begin
      if (g.sel == SEL_W'(r)) lane = live_src[r*BYTE_W +: BYTE_W];
    end
    cand = lane & g.bits;
    low  = '0;
    // Scan from the top so the lowest set bit wins.
    for (int b = BYTE_W - 1; b >= 0; b--) begin
      if (cand[b]) low = BIT_W'(b);
    end
    pick_err = (req_line >= LINE_W'(LINES));
    if (!pick_err && (cand != '0)) pick_vec = {g.sel, low};
    else                           pick_vec = VEC_W'(req_line);
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_vec   <= '0;
      rsp_err   <= 1'b0;
    end else if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      rsp_vec   <= pick_vec;
      rsp_err   <= pick_err;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_tree_ctl.sv
module irq_tree_ctl
  import irq_tree_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  irq_raw,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic [LINES-1:0]  l1_irq,
  input  logic              dmx_req_valid,
  output logic              dmx_req_ready,
  input  logic [LINE_W-1:0] dmx_req_line,
  output logic              dmx_rsp_valid,
  input  logic              dmx_rsp_ready,
  output logic [VEC_W-1:0]  dmx_rsp_vec,
  output logic              dmx_rsp_err
);

  logic [SRC_N-1:0] sync_raw;
  logic [SRC_N-1:0] l2_mask_w;
  logic [LINES-1:0] l1_mask_w;
  logic [SRC_N-1:0] live_w;

  irq_sync #(.W(SRC_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_raw),
    .q     (sync_raw)
  );

  irq_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .sync_raw (sync_raw),
    .rdata    (reg_rdata),
    .l2_mask  (l2_mask_w),
    .l1_mask  (l1_mask_w)
  );

  irq_level_eval u_eval (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_raw (sync_raw),
    .l2_mask  (l2_mask_w),
    .l1_mask  (l1_mask_w),
    .live_src (live_w),
    .l1_irq   (l1_irq)
  );

  irq_demux u_dmx (
    .clk       (clk),
    .rst_n     (rst_n),
    .live_src  (live_w),
    .req_valid (dmx_req_valid),
    .req_ready (dmx_req_ready),
    .req_line  (dmx_req_line),
    .rsp_valid (dmx_rsp_valid),
    .rsp_ready (dmx_rsp_ready),
    .rsp_vec   (dmx_rsp_vec),
    .rsp_err   (dmx_rsp_err)
  );

endmodule

// File: rtl/irq_tree_chk.sv
module irq_tree_chk
  import irq_tree_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [LINES-1:0]  l1_irq,
  input logic [LINES-1:0]  l1_mask,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [BYTE_W-1:0] reg_rdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [VEC_W-1:0]  rsp_vec,
  input logic              rsp_err
);

  // R6: a line masked at the previous edge cannot be asserted now.
  a_r6_masked_line_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_irq & $past(l1_mask)) == '0);

  // R5: unimplemented mask bits of the upper first-level byte read as ones.
  a_r5_upper_nibble_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(L1M_BASE + 1)) |-> (reg_rdata[7:4] == 4'hF));

  // R10: an error response always echoes an out-of-range line.
  a_r10_err_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_vec >= VEC_W'(LINES)));

  // R11: a stalled response stays put.
  a_r11_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_vec) && $stable(rsp_err)));

endmodule

bind irq_tree_ctl irq_tree_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .l1_irq    (l1_irq),
  .l1_mask   (l1_mask_w),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .rsp_valid (dmx_rsp_valid),
  .rsp_ready (dmx_rsp_ready),
  .rsp_vec   (dmx_rsp_vec),
  .rsp_err   (dmx_rsp_err)
);

// File: tb/irq_tree_ctl_tb_top.sv
module irq_tree_ctl_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [31:0] irq_raw = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [11:0] l1_irq;
  logic        dmx_req_valid = 1'b0;
  logic        dmx_req_ready;
  logic [3:0]  dmx_req_line = '0;
  logic        dmx_rsp_valid;
  logic        dmx_rsp_ready = 1'b1;
  logic [4:0]  dmx_rsp_vec;
  logic        dmx_rsp_err;

  irq_tree_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .l1_irq(l1_irq),
    .dmx_req_valid(dmx_req_valid), .dmx_req_ready(dmx_req_ready), .dmx_req_line(dmx_req_line),
    .dmx_rsp_valid(dmx_rsp_valid), .dmx_rsp_ready(dmx_rsp_ready),
    .dmx_rsp_vec(dmx_rsp_vec), .dmx_rsp_err(dmx_rsp_err)
  );

  int vecs = 0;
  int errs = 0;

  // Behavioural reference tables (R3, R6).
  int idle  [4]  = '{8'h00, 8'hBE, 8'hFC, 8'hF7};
  int g_reg [12] = '{2, 2, 3, 3, 1, 2, 1, 0, 1, 1, 3, 2};
  int g_bit [12] = '{8'h40, 8'h80, 8'h08, 8'h01, 8'h01, 8'h3C, 8'h3E, 8'hFF, 8'h40, 8'h80, 8'h06, 8'h03};

  logic [31:0] m_s1, m_s2;
  logic [7:0]  m_l2m [4];
  logic [15:0] m_l1m;
  logic [11:0] m_out;
  logic        m_rv;
  int          m_rvec;
  bit          m_rerr;

  function automatic int live_byte(input int r);
    return (int'(m_s2[r*8 +: 8]) ^ idle[r]) & ~int'(m_l2m[r]) & 8'hFF;
  endfunction

  function automatic void model_dmx(input int ln, output int vec, output bit err);
    err = (ln >= 12);
    vec = ln;
    if (!err) begin
      int c;
      c = live_byte(g_reg[ln]) & g_bit[ln];
      for (int b = 7; b >= 0; b--) if (c[b]) vec = g_reg[ln] * 8 + b;
    end
  endfunction

  function automatic int model_read(input int a);
    if (a < 4)  return int'(m_s2[a*8 +: 8]);
    if (a < 8)  return int'(m_l2m[a-4]);
    if (a == 8) return int'(m_l1m[7:0]);
    if (a == 9) return int'(m_l1m[15:8]);
    return 0;
  endfunction

  logic [11:0] nout;
  bit          m_ready;
  int          dv;
  bit          de;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_out = '0; m_rv = 1'b0; m_rvec = 0; m_rerr = 1'b0;
      for (int r = 0; r < 4; r++) m_l2m[r] = 8'hFF;
      m_l1m = 16'hFFFF;
    end else begin
      for (int n = 0; n < 12; n++)
        nout[n] = !m_l1m[n] && ((live_byte(g_reg[n]) & g_bit[n]) != 0);
      m_ready = !m_rv || dmx_rsp_ready;
      if (m_rv && dmx_rsp_ready) m_rv = 1'b0;
      if (dmx_req_valid && m_ready) begin
        model_dmx(int'(dmx_req_line), dv, de);
        m_rv = 1'b1; m_rvec = dv; m_rerr = de;
      end
      m_out = nout;
      m_s2  = m_s1;
      m_s1  = irq_raw;
      if (reg_wr) begin
        if (reg_addr >= 4 && reg_addr < 8) m_l2m[reg_addr-4] = reg_wdata;
        if (reg_addr == 8) m_l1m[7:0]  = reg_wdata;
        if (reg_addr == 9) m_l1m[15:8] = {4'hF, reg_wdata[3:0]};
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string read_tag(input int a);
    if (a < 4)  return "R2 R3 status read";
    if (a < 8)  return "R4 l2 mask read";
    return "R5 l1 mask read";
  endfunction

  // One clock: wait for the falling edge, compare everything, return to drive.
  task automatic step();
    @(negedge clk);
    if (rst_n) begin
      chk("R3 R6 R7 l1_irq", int'(l1_irq), int'(m_out));
      chk(read_tag(int'(reg_addr)), int'(reg_rdata), model_read(int'(reg_addr)));
      chk("R11 req_ready", int'(dmx_req_ready), int'(!m_rv || dmx_rsp_ready));
      chk("R11 rsp_valid", int'(dmx_rsp_valid), int'(m_rv));
      if (m_rv) begin
        chk("R8 R9 R10 rsp_vec", int'(dmx_rsp_vec), m_rvec);
        chk("R10 rsp_err", int'(dmx_rsp_err), int'(m_rerr));
      end
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
    step();
    reg_wr = 1'b0;
  endtask

  localparam logic [31:0] IDLE_ALL = 32'hF7FC_BE00;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1: reset state at the ports.
    chk("R1 l1_irq after reset", int'(l1_irq), 0);
    chk("R1 rsp_valid after reset", int'(dmx_rsp_valid), 0);
    for (int a = 0; a < 16; a++) begin
      reg_addr = 4'(a);
      step();
      if (a >= 4 && a < 10) chk("R1 mask byte after reset", int'(reg_rdata), 8'hFF);
    end
    // Settle raw inputs at their idle levels; write into status bytes (R2 ignored).
    irq_raw = IDLE_ALL;
    wr(2, 8'h55);
    wr(12, 8'hAA);
    reg_addr = 4'd2; step(); step(); step();
    chk("R2 status write ignored", int'(reg_rdata), 8'hFC);
    wr(9, 8'h00);
    reg_addr = 4'd9; step();
    chk("R5 upper nibble stays set", int'(reg_rdata), 8'hF0);
    for (int a = 4; a < 9; a++) wr(a, 8'h00);
    // Walking single active source over all 32 (R6, R7, R8).
    for (int s = 0; s < 32; s++) begin
      irq_raw = IDLE_ALL ^ (32'd1 << s);
      dmx_req_valid = 1'b1;
      for (int k = 0; k < 5; k++) begin
        dmx_req_line = 4'((s + k * 3) % 16);
        reg_addr = 4'(s % 4);
        step();
      end
      if (s >= 28) chk("R6 unmapped source raises nothing", int'(l1_irq), 0);
    end
    // Two sources in one group: lowest bit must win (R8).
    irq_raw = IDLE_ALL ^ 32'h0000_3E00;
    dmx_req_line = 4'd6;
    repeat (4) step();
    step();
    chk("R8 lowest bit priority", int'(dmx_rsp_vec), 9);
    // Empty group fallback and out-of-range line (R9, R10).
    irq_raw = IDLE_ALL;
    repeat (4) step();
    dmx_req_line = 4'd3; step(); step();
    chk("R9 fallback to line", int'(dmx_rsp_vec), 3);
    dmx_req_line = 4'd14; step(); step();
    chk("R10 out of range echo", int'(dmx_rsp_vec), 14);
    chk("R10 out of range flag", int'(dmx_rsp_err), 1);
    // Random traffic with stalls, mask writes and level changes.
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) irq_raw = IDLE_ALL ^ $urandom();
      reg_wr        = ($urandom_range(0, 7) == 0);
      reg_addr      = 4'($urandom_range(0, 15));
      reg_wdata     = 8'($urandom() & (($urandom_range(0, 1) != 0) ? 32'hFF : 32'h11));
      dmx_req_valid = ($urandom_range(0, 1) != 0);
      dmx_req_line  = 4'($urandom_range(0, 15));
      dmx_rsp_ready = ($urandom_range(0, 2) != 0);
      step();
    end
    reg_wr = 1'b0;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule